// File: doc/BRIEF.md
# Message-Signalled Interrupt Generator with Per-Vector Masking

This block converts per-vector interrupt requests from a function into single 32-bit memory-write messages. The message settings come from capability registers held elsewhere: an enable bit, the number of enabled vectors, the target address, a 16-bit data pattern and one mask bit per vector. Each message leaves on a valid/ready write port as an address, a 32-bit data word and the function's requester ID. When more than one vector is enabled, the vector index replaces the low bits of the data pattern.

A request is never sent straight through. Each legal request first sets a pending bit. A drain engine then issues pending vectors one at a time, lowest index first, and clears each bit in the same cycle its message is loaded. A request for a masked vector only sets its pending bit and does not start the drain, so the vector waits there. A one-cycle rescan pulse from the register block restarts the drain after the mask or count changes. The same pulse also discards pending bits that lie outside the enabled vector range. Requests that arrive while the output is stalled are held as pending bits and are not lost. Only one message is ever outstanding.

Top module: `msi_msg_gen`

## Requirements
- R1: Bits 31:16 of `msg_data` are zero. With an effective log2 vector count L, bits 15:L are `cfg_data[15:L]` and bits L-1:0 are the vector index. With L = 0 the data is `cfg_data` unchanged.
- R2: `msg_addr` equals `cfg_addr` with bits 1:0 forced to zero, and `msg_rid` equals `requester_id`.
- R3: With masking built in (HAS_MASK = 1), a legal request for a vector whose `cfg_mask` bit is 1 sets that bit of `pending` one cycle later and produces no message.
- R4: When enabled, a legal request for an unmasked vector sets its pending bit at the first clock edge. With the output free, its message is presented with `msg_valid` high at the second clock edge and the pending bit clears.
- R5: While `msg_valid` is high and `msg_ready` is low, the message holds steady. Requests that arrive meanwhile are kept as pending bits and are issued after the handshake.
- R6: A rescan pulse while enabled clears the pending bits at or above the enabled count. It then issues the unmasked pending vectors in ascending order, one per accepted message, back to back when `msg_ready` stays high.
- R7: A pending bit left by a masked request is not sent when its mask clears. It stays pending until a rescan pulse (or a later unmasked request) starts the drain.
- R8: A request whose index is at or above the enabled count, while enabled, raises `req_err` for one cycle. It sets no pending bit and produces no message.
- R9: While `cfg_enable` is 0, requests and rescan pulses are ignored and no new message starts. Pending bits are kept.
- R10: A `cfg_log_vec` value above log2(NVEC) is treated as log2(NVEC).
- R11: If a request for a vector arrives in the same cycle that vector's message is issued, the pending bit stays set and a second message follows.
- R12: After reset, `msg_valid`, `req_err` and all `pending` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Message generation enabled |
| cfg_log_vec | input | LOG_W (3) | log2 of enabled vector count |
| cfg_addr | input | ADDR_W (64) | Message target address |
| cfg_data | input | 16 | Message data pattern |
| cfg_mask | input | NVEC (32) | Per-vector mask bits |
| requester_id | input | RID_W (16) | Function requester ID |
| rescan | input | 1 | One-cycle pulse: trim and replay pending vectors |
| req_valid | input | 1 | Interrupt request strobe |
| req_vec | input | VEC_W (5) | Requested vector index |
| req_err | output | 1 | Illegal vector index flagged |
| pending | output | NVEC (32) | Pending vector bits |
| msg_valid | output | 1 | Write message valid |
| msg_ready | input | 1 | Write message accepted |
| msg_addr | output | ADDR_W (64) | Write address |
| msg_data | output | 32 | Write data |
| msg_rid | output | RID_W (16) | Requester ID of the write |

## Verification
Two things can fall in the same cycle. The drain engine may issue a vector, clearing its pending bit, while a new request for that same vector tries to set it. The bench provokes this by driving a second request for a vector on the exact edge its first message is loaded. It then judges that the pending bit survives and that a second identical message follows on the next cycle. A stall release and the issue of the next pending vector also share one edge. The bench checks this by expecting the deferred vector on the output in the very cycle after `msg_ready` rises.

// File: rtl/msi_gen_pkg.sv
// Shared constants and helpers for the message generator.
// Assumes a 16-bit data pattern and dword-aligned message addresses.
package msi_gen_pkg;
    localparam int unsigned PAT_W      = 16;
    localparam int unsigned MSG_W      = 32;
    localparam int unsigned ALIGN_BITS = 2;

    // Clamp a requested log2 count to the supported maximum
    function automatic int unsigned clamp_log(input int unsigned req, input int unsigned lmax);
        return (req > lmax) ? lmax : req;
    endfunction
endpackage

// File: rtl/msi_range_decode.sv
// Decodes the programmed log2 vector count into an effective (clamped)
// count and a per-vector in-range mask. Assumes NVEC is a power of two.
module msi_range_decode #(
    parameter int unsigned NVEC  = 32,
    localparam int unsigned VEC_W = $clog2(NVEC),
    localparam int unsigned LOG_W = $clog2(VEC_W + 1)
) (
    input  logic [LOG_W-1:0] cfg_log_vec,
    output logic [LOG_W-1:0] log_eff,
    output logic [NVEC-1:0]  in_range
);
    import msi_gen_pkg::*;

    // Clamp the count field to what the block supports
    always_comb begin
        log_eff = LOG_W'(clamp_log(int'(cfg_log_vec), VEC_W));
    end

    // One comparator per vector: inside the enabled range or not
    for (genvar i = 0; i < NVEC; i++) begin : g_rng
        always_comb begin
            in_range[i] = (i < (1 << log_eff));
        end
    end
endmodule

// File: rtl/msi_low_pick.sv
// Finds the lowest set bit of a request vector: flag, one-hot and index.
// Purely combinational; lowest index has priority.
module msi_low_pick #(
    parameter int unsigned NVEC  = 32,
    localparam int unsigned VEC_W = $clog2(NVEC)
) (
    input  logic [NVEC-1:0]  cand,
    output logic             any,
    output logic [NVEC-1:0]  onehot,
    output logic [VEC_W-1:0] idx
);
    logic [NVEC:0] seen;

    assign seen[0] = 1'b0;

    // Ripple a "lower bit already taken" chain across the vector
    for (genvar i = 0; i < NVEC; i++) begin : g_chain
        assign onehot[i]  = cand[i] & ~seen[i];
        assign seen[i+1]  = seen[i] | cand[i];
    end

    assign any = seen[NVEC];

    // Encode the one-hot winner into a binary index
    always_comb begin
        idx = '0;
        for (int i = 0; i < NVEC; i++) begin
            if (onehot[i]) idx = idx | VEC_W'(i);
        end
    end
endmodule

// File: rtl/msi_data_merge.sv
// Builds the 32-bit message word: the 16-bit pattern zero-extended, with
// the low log_eff bits replaced by the vector index. Assumes VEC_W <= 16.
module msi_data_merge #(
    parameter int unsigned NVEC  = 32,
    localparam int unsigned VEC_W = $clog2(NVEC),
    localparam int unsigned LOG_W = $clog2(VEC_W + 1)
) (
    input  logic [msi_gen_pkg::PAT_W-1:0] pattern,
    input  logic [LOG_W-1:0]              log_eff,
    input  logic [VEC_W-1:0]              vec,
    output logic [msi_gen_pkg::MSG_W-1:0] word
);
    import msi_gen_pkg::*;

    logic [PAT_W-1:0] low_mask;

    // Merge the vector index into the low bits of the pattern
    always_comb begin
        low_mask = PAT_W'((17'd1 << log_eff) - 17'd1);
        word     = {{(MSG_W-PAT_W){1'b0}},
                    (pattern & ~low_mask) | (PAT_W'(vec) & low_mask)};
    end
endmodule

// File: rtl/msi_msg_gen.sv
// Top: converts vector requests into single write messages. Every legal
// request is recorded as a pending bit; a drain engine issues eligible
// pending vectors lowest-first, one outstanding message at a time.
// Assumes configuration inputs are quasi-static, sampled at issue.
module msi_msg_gen #(
    parameter int unsigned NVEC     = 32,
    parameter int unsigned ADDR_W   = 64,
    parameter int unsigned RID_W    = 16,
    parameter bit          HAS_MASK = 1'b1,
    localparam int unsigned VEC_W   = $clog2(NVEC),
    localparam int unsigned LOG_W   = $clog2(VEC_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [LOG_W-1:0]  cfg_log_vec,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [15:0]       cfg_data,
    input  logic [NVEC-1:0]   cfg_mask,
    input  logic [RID_W-1:0]  requester_id,
    input  logic              rescan,
    input  logic              req_valid,
    input  logic [VEC_W-1:0]  req_vec,
    output logic              req_err,
    output logic [NVEC-1:0]   pending,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [ADDR_W-1:0] msg_addr,
    output logic [31:0]       msg_data,
    output logic [RID_W-1:0]  msg_rid
);
    import msi_gen_pkg::*;

    logic [LOG_W-1:0] log_eff;
    logic [NVEC-1:0]  in_range;
    logic [NVEC-1:0]  mask_eff;
    logic [NVEC-1:0]  pend_q, pend_nxt;
    logic [NVEC-1:0]  eligible, pick_oh, clr_bits, set_bits, keep_bits;
    logic [VEC_W-1:0] pick_idx;
    logic             pick_any;
    logic             drain_q, drain_nxt;
    logic             req_hit, req_ok, req_bad, req_masked;
    logic             rescan_act, slot_free, issue;
    logic [MSG_W-1:0] word;
    logic             valid_q, err_q;
    logic [ADDR_W-1:0] addr_q;
    logic [MSG_W-1:0]  data_q;
    logic [RID_W-1:0]  rid_q;

    msi_range_decode #(.NVEC(NVEC)) u_rng (
        .cfg_log_vec (cfg_log_vec),
        .log_eff     (log_eff),
        .in_range    (in_range)
    );

    msi_low_pick #(.NVEC(NVEC)) u_pick (
        .cand   (eligible),
        .any    (pick_any),
        .onehot (pick_oh),
        .idx    (pick_idx)
    );

    msi_data_merge #(.NVEC(NVEC)) u_merge (
        .pattern (cfg_data),
        .log_eff (log_eff),
        .vec     (pick_idx),
        .word    (word)
    );

    // Masking capability is a build option; without it nothing is masked
    if (HAS_MASK) begin : g_mask
        assign mask_eff = cfg_mask;
    end else begin : g_nomask
        assign mask_eff = '0;
    end

    // Classify the incoming request
    always_comb begin
        req_hit    = req_valid & cfg_enable;
        req_ok     = req_hit & in_range[req_vec];
        req_bad    = req_hit & ~in_range[req_vec];
        req_masked = mask_eff[req_vec];
        set_bits   = req_ok ? (NVEC'(1) << req_vec) : '0;
        rescan_act = rescan & cfg_enable;
    end

    // Choose whether a pending vector is issued this cycle
    always_comb begin
        eligible  = pend_q & ~mask_eff & in_range;
        slot_free = ~valid_q | msg_ready;
        issue     = cfg_enable & drain_q & pick_any & slot_free;
        clr_bits  = issue ? pick_oh : '0;
    end

    // Next pending set: issue clears, rescan trims, new request sets
    always_comb begin
        keep_bits = rescan_act ? in_range : '1;
        pend_nxt  = ((pend_q & ~clr_bits) & keep_bits) | set_bits;
        drain_nxt = (req_ok & ~req_masked) | rescan_act
                  | (drain_q & |(eligible & ~clr_bits));
    end

    // Pending bits and drain flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            drain_q <= 1'b0;
        end else begin
            pend_q  <= pend_nxt;
            drain_q <= drain_nxt;
        end
    end

    // Output message register: load on issue, drop on handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            rid_q   <= '0;
        end else if (issue) begin
            valid_q <= 1'b1;
            addr_q  <= {cfg_addr[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
            data_q  <= word;
            rid_q   <= requester_id;
        end else if (msg_ready) begin
            valid_q <= 1'b0;
        end
    end

    // Illegal-index flag, one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= req_bad;
    end

    assign req_err   = err_q;
    assign pending   = pend_q;
    assign msg_valid = valid_q;
    assign msg_addr  = addr_q;
    assign msg_data  = data_q;
    assign msg_rid   = rid_q;
endmodule

// File: rtl/msi_msg_gen_chk.sv
// Port-level property checker for msi_msg_gen, attached by bind.
module msi_msg_gen_chk #(
    parameter int unsigned NVEC     = 32,
    parameter int unsigned ADDR_W   = 64,
    parameter int unsigned RID_W    = 16,
    parameter bit          HAS_MASK = 1'b1,
    localparam int unsigned VEC_W   = $clog2(NVEC),
    localparam int unsigned LOG_W   = $clog2(VEC_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_enable,
    input logic [LOG_W-1:0]  cfg_log_vec,
    input logic [NVEC-1:0]   cfg_mask,
    input logic              req_valid,
    input logic [VEC_W-1:0]  req_vec,
    input logic              req_err,
    input logic [NVEC-1:0]   pending,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [ADDR_W-1:0] msg_addr,
    input logic [31:0]       msg_data
);
    int unsigned lg;
    logic        legal;

    // Legality of the request index seen from the ports
    always_comb begin
        lg    = (int'(cfg_log_vec) > VEC_W) ? VEC_W : int'(cfg_log_vec);
        legal = (int'(req_vec) < (1 << lg));
    end

    // R2
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_addr[1:0] == 2'b00));

    // R1
    data_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_data[31:16] == 16'h0000));

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_data) && $stable(msg_addr)));

    // R8
    bad_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_enable && !legal) |=> req_err);

    // R3
    mask_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_MASK && req_valid && cfg_enable && legal && cfg_mask[req_vec])
            |=> pending[$past(req_vec)]);

    // R9
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !$rose(msg_valid));
endmodule

bind msi_msg_gen msi_msg_gen_chk #(
    .NVEC(NVEC), .ADDR_W(ADDR_W), .RID_W(RID_W), .HAS_MASK(HAS_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_log_vec(cfg_log_vec),
    .cfg_mask(cfg_mask), .req_valid(req_valid), .req_vec(req_vec),
    .req_err(req_err), .pending(pending), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/sim_msi_msg_gen.sv
module sim_msi_msg_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [2:0]  cfg_log_vec = '0;
    logic [63:0] cfg_addr = 64'h0000_0001_2345_6787;
    logic [15:0] cfg_data = '0;
    logic [31:0] cfg_mask = '0;
    logic [15:0] requester_id = 16'h3A5C;
    logic        rescan = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_vec = '0;
    logic        req_err;
    logic [31:0] pending;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;
    logic [15:0] msg_rid;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    msi_msg_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_log_vec(cfg_log_vec),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_mask(cfg_mask),
        .requester_id(requester_id), .rescan(rescan), .req_valid(req_valid),
        .req_vec(req_vec), .req_err(req_err), .pending(pending),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
        .msg_data(msg_data), .msg_rid(msg_rid)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] expd(input logic [15:0] d, input int lg, input int v);
        logic [15:0] m;
        m = 16'((1 << lg) - 1);
        return {16'h0, (d & ~m) | (16'(v) & m)};
    endfunction

    task automatic request(input int v);
        req_valid = 1'b1;
        req_vec   = 5'(v);
        tick();
        req_valid = 1'b0;
    endtask

    task automatic expect_msg(input string tag, input int lg, input int v);
        chk(msg_valid === 1'b1, {tag, " valid"}, 64'(msg_valid), 64'd1);
        chk(msg_data === expd(cfg_data, lg, v), {tag, " data"}, 64'(msg_data), 64'(expd(cfg_data, lg, v)));
    endtask

    task automatic t_reset();
        repeat (3) tick();
        // R12
        chk(msg_valid === 1'b0 && req_err === 1'b0 && pending === '0, "R12 reset state",
            {31'd0, msg_valid, pending}, 64'd0);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_single();
        cfg_enable = 1; cfg_log_vec = 0; cfg_data = 16'hABCD; msg_ready = 1;
        request(0);
        // R4
        chk(pending[0] === 1'b1 && msg_valid === 1'b0, "R4 pending first edge", {pending, 31'd0, msg_valid}, {32'd1, 32'd0});
        tick();
        expect_msg("R4 R1 single vector", 0, 0);
        // R2
        chk(msg_addr === 64'h0000_0001_2345_6784, "R2 address", msg_addr, 64'h0000_0001_2345_6784);
        chk(msg_rid === 16'h3A5C, "R2 requester id", 64'(msg_rid), 64'h3A5C);
        chk(pending === '0, "R4 pending cleared", 64'(pending), 64'd0);
        tick();
        chk(msg_valid === 1'b0, "R4 single message only", 64'(msg_valid), 64'd0);
    endtask

    task automatic t_merge();
        cfg_log_vec = 3; cfg_data = 16'h1230;
        request(5); tick();
        expect_msg("R1 merge vec5", 3, 5);
        tick();
        cfg_data = 16'hFFFF;
        request(2); tick();
        expect_msg("R1 merge vec2", 3, 2);
        tick();
    endtask

    task automatic t_illegal();
        cfg_log_vec = 2;
        request(6);
        // R8
        chk(req_err === 1'b1, "R8 error flag", 64'(req_err), 64'd1);
        chk(pending === '0, "R8 no pending", 64'(pending), 64'd0);
        tick();
        chk(req_err === 1'b0 && msg_valid === 1'b0, "R8 pulse and no message", {req_err, msg_valid}, 64'd0);
    endtask

    task automatic t_clamp();
        cfg_log_vec = 7; cfg_data = 16'h0000;
        request(31);
        // R10
        chk(req_err === 1'b0, "R10 vec31 legal", 64'(req_err), 64'd0);
        tick();
        expect_msg("R10 clamp to 32 vectors", 5, 31);
        tick();
    endtask

    task automatic t_mask();
        cfg_log_vec = 3; cfg_data = 16'h4440; cfg_mask = 32'h8;
        request(3);
        // R3
        chk(pending === 32'h8, "R3 masked goes pending", 64'(pending), 64'h8);
        tick(); tick();
        chk(msg_valid === 1'b0, "R3 no message while masked", 64'(msg_valid), 64'd0);
        cfg_mask = 0;
        tick(); tick(); tick();
        // R7
        chk(msg_valid === 1'b0 && pending === 32'h8, "R7 waits for rescan", {31'd0, msg_valid, pending}, 64'h8);
        rescan = 1; tick(); rescan = 0;
        tick();
        expect_msg("R7 replay after rescan", 3, 3);
        chk(pending === '0, "R6 replay clears pending", 64'(pending), 64'd0);
        tick();
    endtask

    task automatic t_order();
        cfg_log_vec = 4; cfg_data = 16'h0100; cfg_mask = 32'h0000_1052;
        request(12); request(6); request(4); request(1);
        chk(pending === 32'h0000_1052, "R3 four masked pending", 64'(pending), 64'h1052);
        cfg_log_vec = 3; cfg_mask = 0;
        rescan = 1; tick(); rescan = 0;
        // R6
        chk(pending === 32'h52, "R6 out-of-range discarded", 64'(pending), 64'h52);
        tick(); expect_msg("R6 order first", 3, 1);
        tick(); expect_msg("R6 order second", 3, 4);
        tick(); expect_msg("R6 order third", 3, 6);
        tick();
        chk(msg_valid === 1'b0 && pending === '0, "R6 drain complete", {31'd0, msg_valid, pending}, 64'd0);
    endtask

    task automatic t_stall();
        cfg_log_vec = 3; cfg_data = 16'h7700; msg_ready = 0;
        request(2);
        request(5);
        expect_msg("R5 first under stall", 3, 2);
        chk(pending === 32'h20, "R5 deferred pending", 64'(pending), 64'h20);
        tick(); tick(); tick();
        expect_msg("R5 held while stalled", 3, 2);
        msg_ready = 1;
        tick();
        expect_msg("R5 deferred issued at release", 3, 5);
        tick();
        chk(msg_valid === 1'b0, "R5 idle after drain", 64'(msg_valid), 64'd0);
    endtask

    task automatic t_collide();
        cfg_log_vec = 3; cfg_data = 16'h0A00;
        request(3);
        request(3);
        // R11
        expect_msg("R11 first message", 3, 3);
        chk(pending === 32'h8, "R11 bit survives", 64'(pending), 64'h8);
        tick();
        expect_msg("R11 second message", 3, 3);
        tick();
        chk(msg_valid === 1'b0 && pending === '0, "R11 exactly two", {31'd0, msg_valid, pending}, 64'd0);
    endtask

    task automatic t_disable();
        cfg_log_vec = 3; cfg_data = 16'h0C00; cfg_mask = 32'h4;
        request(2);
        cfg_enable = 0; cfg_mask = 0;
        request(1);
        // R9
        chk(pending === 32'h4 && req_err === 1'b0, "R9 request ignored", 64'(pending), 64'h4);
        rescan = 1; tick(); rescan = 0;
        tick(); tick();
        chk(msg_valid === 1'b0 && pending === 32'h4, "R9 rescan ignored, pending kept", {31'd0, msg_valid, pending}, 64'h4);
        cfg_enable = 1;
        rescan = 1; tick(); rescan = 0;
        tick();
        expect_msg("R9 delivered after re-enable", 3, 2);
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single();
        t_merge();
        t_illegal();
        t_clamp();
        t_mask();
        t_order();
        t_stall();
        t_collide();
        t_disable();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule